// File: doc/BRIEF.md
# Radio Burst Strobe Sequencer

This block produces the power and mode strobes that a baseband controller sends to a 2.4 GHz frequency-hopping radio for one transmit or receive burst that lasts 1, 3 or 5 slots of 625 µs. Software first posts a request, which gives the direction, the slot count and two hold options. The next slot-boundary pulse then starts the burst. From that point a counter advances on a 1 MHz timing tick and sets the rise of each strobe at a fixed microsecond offset. At the end of the data period all strobes fall on the same tick.

For a transmit burst, the synthesizer strobe and the transmit strobe rise together at the start. The phase-detector-open strobe rises 206 µs later. A transmit-data window then opens at 213 µs. For a receive burst, the synthesizer strobe rises at the start, the receiver strobe rises at 175 µs, and the receive-data qualifier opens at 213 µs. The packet strobe marks the payload once the correlator reports that the header is done. It selects the slower and more precise frequency-compensation mode. Two hold options each extend the fall of one strobe by 6 µs: the phase-detector strobe or the synthesizer strobe. A request that arrives while another request is pending or a burst is running is dropped and reported.

Top module: `slot_burst_seq`

## Requirements
- R1: A request made while idle is stored. No strobe rises until the next slot pulse, which starts the burst with the tick count at 0.
- R2: In a transmit burst (req_rx=0), synth_on and tx_on are high from count 0. phd_off rises when the count reaches 206.
- R3: In a transmit burst, tx_win is high from count 213 for the data period. The data period is 366, 1598 or 2862 ticks for req_len codes 0, 1 and 2 respectively, and code 3 also gives 2862 ticks.
- R4: In a receive burst (req_rx=1), synth_on is high from count 0, rx_on from count 175, and rx_win from count 213 for the same data period as R3.
- R5: tx_on and rx_on are never high together, and synth_on is high whenever either of them is.
- R6: pkt_on is high only inside rx_win, from the cycle after hdr_done is seen inside rx_win until the window closes. A hdr_done outside rx_win has no effect.
- R7: When the data period ends, every strobe and window falls on the same tick, except a strobe held by R8.
- R8: With cfg_phd_hold, phd_off stays high for 6 more ticks after the end of the data period. With cfg_syn_hold, synth_on stays high for 6 more ticks. Both options are taken at the moment the request is accepted.
- R9: A request made while a request is pending or a burst is running is dropped. req_err is then high for exactly the next cycle.
- R10: Slot pulses during a burst have no effect, and the count advances only on cycles with tick_us high.
- R11: After reset every output is low and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle 1 MHz timing enable |
| slot_pulse | input | 1 | Slot-boundary pulse |
| req_valid | input | 1 | Burst request strobe |
| req_rx | input | 1 | Direction: 1 receive, 0 transmit |
| req_len | input | 2 | Slot count code: 0 one, 1 three, 2 or 3 five |
| cfg_phd_hold | input | 1 | Extend the fall of phd_off by 6 ticks |
| cfg_syn_hold | input | 1 | Extend the fall of synth_on by 6 ticks |
| hdr_done | input | 1 | Header-complete pulse from the correlator |
| synth_on | output | 1 | Synthesizer power strobe |
| tx_on | output | 1 | Transmitter power strobe |
| phd_off | output | 1 | Open-loop (phase detector off) strobe |
| rx_on | output | 1 | Receiver power strobe |
| pkt_on | output | 1 | Payload / slow compensation strobe |
| tx_win | output | 1 | Transmit-data gate window |
| rx_win | output | 1 | Receive-data qualify window |
| req_err | output | 1 | One-cycle pulse for a dropped request |

## Verification
The bench builds the block with its default offsets and data periods, so the 5-slot length of 2862 ticks and the 6-tick holds run at their real values. It drives the timing tick on every clock in most runs and on every second clock in one run. A full five-slot burst with both holds therefore fits in a few thousand cycles, and the check of a count that advances only on tick cycles is exercised. The runs cover both directions, every length code including the alias code, each hold option alone and both together, a header pulse outside the window, and requests and slot pulses that arrive in the pending and running phases.

// File: rtl/slot_burst_seq.sv
module slot_burst_seq #(
  parameter int PHD_US   = 206,
  parameter int TXDAT_US = 213,
  parameter int RXON_US  = 175,
  parameter int RXDAT_US = 213,
  parameter int LEN1_US  = 366,
  parameter int LEN3_US  = 1598,
  parameter int LEN5_US  = 2862,
  parameter int HOLD_US  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       slot_pulse,
  input  logic       req_valid,
  input  logic       req_rx,
  input  logic [1:0] req_len,
  input  logic       cfg_phd_hold,
  input  logic       cfg_syn_hold,
  input  logic       hdr_done,
  output logic       synth_on,
  output logic       tx_on,
  output logic       phd_off,
  output logic       rx_on,
  output logic       pkt_on,
  output logic       tx_win,
  output logic       rx_win,
  output logic       req_err
);
  localparam int MAXW = (TXDAT_US > RXDAT_US) ? TXDAT_US : RXDAT_US;
  localparam int CW   = $clog2(MAXW + LEN5_US + HOLD_US + 1);
  localparam logic [CW-1:0] C_PHD  = CW'(PHD_US);
  localparam logic [CW-1:0] C_TXD  = CW'(TXDAT_US);
  localparam logic [CW-1:0] C_RXON = CW'(RXON_US);
  localparam logic [CW-1:0] C_RXD  = CW'(RXDAT_US);
  localparam logic [CW-1:0] C_L1   = CW'(LEN1_US);
  localparam logic [CW-1:0] C_L3   = CW'(LEN3_US);
  localparam logic [CW-1:0] C_L5   = CW'(LEN5_US);
  localparam logic [CW-1:0] C_HOLD = CW'(HOLD_US);
  localparam logic [CW-1:0] C_ONE  = CW'(1);

  logic          armed, run, dir_rx, hold_p, hold_s, hdr_seen;
  logic [1:0]    len_q;
  logic [CW-1:0] cnt;

  logic [CW-1:0] data_len, win_lo, win_end, last;
  logic          main, tail, start, finish;

  assign data_len = (len_q == 2'd0) ? C_L1 : (len_q == 2'd1) ? C_L3 : C_L5;
  assign win_lo   = dir_rx ? C_RXD : C_TXD;
  assign win_end  = win_lo + data_len;
  assign last     = win_end + (((hold_p && !dir_rx) || hold_s) ? C_HOLD : '0);

  assign main   = run && (cnt < win_end);
  assign tail   = run && (cnt >= win_end);
  assign start  = armed && slot_pulse;
  assign finish = run && tick_us && (cnt == last - C_ONE);

  assign synth_on = main || (tail && hold_s);
  assign tx_on    = main && !dir_rx;
  assign phd_off  = run && !dir_rx && (cnt >= C_PHD) && (main || hold_p);
  assign tx_win   = main && !dir_rx && (cnt >= C_TXD);
  assign rx_on    = main && dir_rx && (cnt >= C_RXON);
  assign rx_win   = main && dir_rx && (cnt >= C_RXD);
  assign pkt_on   = rx_win && hdr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      run      <= 1'b0;
      dir_rx   <= 1'b0;
      len_q    <= 2'd0;
      hold_p   <= 1'b0;
      hold_s   <= 1'b0;
      hdr_seen <= 1'b0;
      cnt      <= '0;
      req_err  <= 1'b0;
    end else begin
      req_err <= req_valid && (armed || run);
      if (start) begin
        armed    <= 1'b0;
        run      <= 1'b1;
        cnt      <= '0;
        hdr_seen <= 1'b0;
      end else if (finish) begin
        run      <= 1'b0;
        cnt      <= '0;
        hdr_seen <= 1'b0;
      end else begin
        if (run && tick_us) cnt <= cnt + C_ONE;
        if (rx_win && hdr_done) hdr_seen <= 1'b1;
      end
      if (req_valid && !armed && !run) begin
        armed  <= 1'b1;
        dir_rx <= req_rx;
        len_q  <= req_len;
        hold_p <= cfg_phd_hold;
        hold_s <= cfg_syn_hold;
      end
    end
  end
endmodule

// File: rtl/slot_burst_seq_chk.sv
module slot_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic synth_on,
  input logic tx_on,
  input logic phd_off,
  input logic rx_on,
  input logic pkt_on,
  input logic tx_win,
  input logic rx_win,
  input logic req_err
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R5
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_on && rx_on));
  // R5
  synth_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on || rx_on) |-> synth_on);
  // R2
  phd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $rose(phd_off) |-> tx_on);
  // R3
  txwin_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_win |-> (phd_off && tx_on));
  // R6
  pkt_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_on |-> rx_win);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    req_err |-> $past(req_valid));
  // R7
  drop_same_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $fell(tx_win) |-> !tx_on);
endmodule

bind slot_burst_seq slot_burst_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .synth_on(synth_on), .tx_on(tx_on), .phd_off(phd_off), .rx_on(rx_on),
  .pkt_on(pkt_on), .tx_win(tx_win), .rx_win(rx_win), .req_err(req_err)
);

// File: tb/slot_burst_seq_tb.sv
`timescale 1ns/1ps
module slot_burst_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_us = 1'b0, slot_pulse = 1'b0, req_valid = 1'b0, req_rx = 1'b0;
  logic [1:0] req_len = 2'd0;
  logic cfg_phd_hold = 1'b0, cfg_syn_hold = 1'b0, hdr_done = 1'b0;
  logic synth_on, tx_on, phd_off, rx_on, pkt_on, tx_win, rx_win, req_err;

  always #4 clk = ~clk;

  slot_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .slot_pulse(slot_pulse),
    .req_valid(req_valid), .req_rx(req_rx), .req_len(req_len),
    .cfg_phd_hold(cfg_phd_hold), .cfg_syn_hold(cfg_syn_hold), .hdr_done(hdr_done),
    .synth_on(synth_on), .tx_on(tx_on), .phd_off(phd_off), .rx_on(rx_on),
    .pkt_on(pkt_on), .tx_win(tx_win), .rx_win(rx_win), .req_err(req_err)
  );

  int total = 0, bad = 0;
  int tick_div = 1, tick_ph = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference: 0 idle, 1 pending, 2 running
  int m_st = 0, m_us = 0, m_len = 0;
  bit m_rx = 0, m_hp = 0, m_hs = 0, m_hdr = 0, m_err = 0;

  function automatic int span(int code);
    return (code == 0) ? 366 : (code == 1) ? 1598 : 2862;
  endfunction
  function automatic int e_end();
    return 213 + span(m_len);
  endfunction
  function automatic int e_last();
    return e_end() + ((m_hs || (m_hp && !m_rx)) ? 6 : 0);
  endfunction
  function automatic bit in_data();
    return m_st == 2 && m_us < e_end();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_us = 0; m_hdr = 0; m_err = 0;
    end else begin
      int pre;
      bit rwin;
      pre  = m_st;
      rwin = in_data() && m_rx && m_us >= 213;
      m_err = req_valid && pre != 0;
      if (pre == 1 && slot_pulse) begin
        m_st = 2; m_us = 0; m_hdr = 0;
      end else if (pre == 2 && tick_us && m_us + 1 == e_last()) begin
        m_st = 0; m_us = 0; m_hdr = 0;
      end else begin
        if (pre == 2 && tick_us) m_us++;
        if (rwin && hdr_done) m_hdr = 1;
      end
      if (req_valid && pre == 0) begin
        m_st = 1; m_rx = req_rx; m_len = int'(req_len);
        m_hp = cfg_phd_hold; m_hs = cfg_syn_hold;
      end
    end
  end

  task automatic chk(bit act, bit exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cycles, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit d, run, tail;
      d    = in_data();
      run  = m_st == 2;
      tail = run && !d;
      chk(synth_on, d || (tail && m_hs), "R2/R4/R8 synth_on");
      chk(tx_on, d && !m_rx, "R2 tx_on");
      chk(phd_off, run && !m_rx && m_us >= 206 && (d || m_hp), "R2/R8 phd_off");
      chk(tx_win, d && !m_rx && m_us >= 213, "R3 tx_win");
      chk(rx_on, d && m_rx && m_us >= 175, "R4 rx_on");
      chk(rx_win, d && m_rx && m_us >= 213, "R4 rx_win");
      chk(pkt_on, d && m_rx && m_us >= 213 && m_hdr, "R6 pkt_on");
      chk(req_err, m_err, "R9 req_err");
      chk(!(tx_on && rx_on), 1'b1, "R5 exclusion");
    end
  end

  always @(negedge clk) begin
    if (tick_div <= 1) tick_us <= 1'b1;
    else begin
      tick_us <= (tick_ph == 0);
      tick_ph <= (tick_ph + 1) % tick_div;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic request(bit rx, logic [1:0] len, bit hp, bit hs);
    @(negedge clk);
    req_valid = 1; req_rx = rx; req_len = len; cfg_phd_hold = hp; cfg_syn_hold = hs;
    @(negedge clk);
    req_valid = 0; cfg_phd_hold = 0; cfg_syn_hold = 0;
  endtask

  task automatic pulse_slot();
    @(negedge clk); slot_pulse = 1;
    @(negedge clk); slot_pulse = 0;
  endtask

  task automatic wait_idle();
    while (m_st != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R7: after the end every strobe is back low
    chk(synth_on | tx_on | phd_off | rx_on | pkt_on | tx_win | rx_win, 1'b0, "R7 all low after end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(synth_on | tx_on | phd_off | rx_on | pkt_on | tx_win | rx_win | req_err, 1'b0, "R11 reset outputs");
    rst_n = 1;
    repeat (2) @(negedge clk);

    // transmit, one slot
    request(0, 2'd0, 0, 0);
    repeat (10) @(negedge clk);
    chk(synth_on, 1'b0, "R1 idle before slot pulse");
    pulse_slot();
    chk(synth_on && tx_on, 1'b1, "R2 strobes at start");
    wait_idle();

    // receive, three slots, header pulse outside then inside the window
    request(1, 2'd1, 0, 0);
    pulse_slot();
    repeat (50) @(negedge clk);
    hdr_done = 1; @(negedge clk); hdr_done = 0;   // R6 ignored outside window
    repeat (300) @(negedge clk);
    chk(pkt_on, 1'b0, "R6 early header ignored");
    hdr_done = 1; @(negedge clk); hdr_done = 0;
    chk(pkt_on, 1'b1, "R6 pkt_on after header");
    wait_idle();

    // transmit, five slots, both holds, tick every second clock (R10)
    tick_div = 2;
    request(0, 2'd2, 1, 1);
    pulse_slot();
    repeat (100) @(negedge clk);
    pulse_slot();                                  // R10 ignored mid-burst
    wait_idle();
    tick_div = 1;

    // receive, one slot, synthesizer hold only
    request(1, 2'd0, 0, 1);
    pulse_slot();
    wait_idle();

    // transmit, phase-detector hold only, code 3 alias
    request(0, 2'd3, 1, 0);
    request(1, 2'd0, 0, 0);                        // R9 rejected while pending
    pulse_slot();
    repeat (20) @(negedge clk);
    request(1, 2'd1, 1, 1);                        // R9 rejected while running
    wait_idle();

    // transmit, one slot, synthesizer hold
    request(0, 2'd0, 0, 1);
    pulse_slot();
    wait_idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule